// File: doc/BRIEF.md
# Dual-Product Interleaved Systolic Scheduler

The block evaluates two independent banded matrix-vector products on one linear systolic array of `W` multiply-accumulate cells. The two operand vectors are merged element by element into a single carrier of `2N` slots, with the first product on even slots and the second on odd slots. The two coefficient sets are merged the same way. Each carrier row then passes through the cell chain as a moving partial sum. Cell `d` owns one diagonal of the merged band, so the idle alternate cycles of a single product are filled by the other product. Any operand element can be flagged as don't-care. It then contributes nothing to either product, and its own result slot comes out flagged invalid.

A second pass through the same array applies a fixed pair of 0/1 matrices to the first pass's results. The pair is chosen by the first carrier component, which is element 0 of result A. When that component is zero, A passes through unchanged and B has each adjacent element pair swapped. Otherwise both pass unchanged. A de-interleaver returns the final carrier as two result vectors, each with a per-element valid mask. Entries are plain signed integers, and no normalising factor is applied.

A job is taken on a valid/ready handshake. The block holds `in_ready` low until its result has been taken. The result is offered on a second valid/ready handshake and is held steady for as long as the consumer keeps `out_ready` low.

Top module: `dual_systolic_sched`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Pass one computes result A slot k as the sum of `in_mat_a[k][c]*in_xa[c]` and result B slot k as the sum of `in_mat_b[k][c]*in_xb[c]`, both in the same pass. In the carrier, slot 2k holds vector element A[k] and slot 2k+1 holds B[k]. Matrix entry (r,c) sits at bits `[(r*N+c)*DW +: DW]`, and vector element k at `[k*DW +: DW]`.
- R3: A matrix entry with |r−c| > (W−1)/2 is ignored. Changing its value does not change any output.
- R4: An operand element whose mask bit (`in_xa_vld[k]` or `in_xb_vld[k]`) is 0 adds zero to every product. The result slot with the same index reads 0 and carries mask bit 0.
- R5: If pass-one result A[0] is 0, or is invalid, pass two keeps A and swaps B elements 2j and 2j+1, values and masks alike, and `out_pair_swap` is 1. Otherwise both vectors pass unchanged and `out_pair_swap` is 0.
- R6: Once both passes have run, `out_valid` rises. `out_a`/`out_b` hold the pass-two results at `[k*AW +: AW]`, and `out_a_vld`/`out_b_vld` hold their masks.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and all result outputs hold their values.
- R8: `in_ready` is 0 from the accepting edge until the cycle after the result handshake, and `in_valid` has no effect meanwhile. After `out_valid && out_ready`, the next cycle has `out_valid` 0 and `in_ready` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Job offered |
| in_ready | output | 1 | Block idle, job accepted when in_valid is high |
| in_xa | input | N*DW | Operand vector for product A |
| in_xa_vld | input | N | Per-element mask for in_xa, 0 = don't-care |
| in_xb | input | N*DW | Operand vector for product B |
| in_xb_vld | input | N | Per-element mask for in_xb |
| in_mat_a | input | N*N*DW | Row-major coefficients for product A |
| in_mat_b | input | N*N*DW | Row-major coefficients for product B |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_a | output | N*AW | Final result vector A |
| out_a_vld | output | N | Mask for out_a |
| out_b | output | N*AW | Final result vector B |
| out_b_vld | output | N | Mask for out_b |
| out_pair_swap | output | 1 | Pass two used the swap pair on B |

## Verification
The assertions assume that sums stay within `AW` bits. They also assume that a consumer seeing `out_valid` eventually raises `out_ready`, and that `in_valid` is only acted on while `in_ready` is high. The bench uses small coefficients and operands, so no sum approaches the accumulator range. It always completes each result handshake. It deliberately drives `in_valid` with different data during a busy job, so that the block's refusal of that data is observed at the result ports.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RUN1,
    PH_PICK,
    PH_RUN2,
    PH_DONE
  } sched_phase_e;

endpackage

// File: rtl/sched_row_gen.sv
// Builds the operand window for one carrier row: one coefficient, operand and
// operand-valid per cell, plus the row's own validity.
module sched_row_gen #(
  parameter int N  = 4,
  parameter int W  = 3,
  parameter int DW = 8,
  parameter int AW = 20,
  localparam int M  = 2 * N,
  localparam int IW = $clog2(M),
  localparam int HB = (W - 1) / 2
) (
  input  logic                    second,
  input  logic                    swap,
  input  logic [IW-1:0]           row,
  input  logic signed [AW-1:0]    car_x [M],
  input  logic [M-1:0]            car_v,
  input  logic [N*N*DW-1:0]       mat_a,
  input  logic [N*N*DW-1:0]       mat_b,
  output logic signed [DW-1:0]    op_coef [W],
  output logic signed [AW-1:0]    op_x [W],
  output logic [W-1:0]            op_xv,
  output logic                    row_v
);

  always_comb begin
    int r;
    int p;
    int tgt;
    r   = int'(row[IW-1:1]);
    p   = int'(row[0]);
    tgt = (second && swap && p == 1) ? (r ^ 1) : r;
    row_v = second ? car_v[2*tgt+p] : car_v[2*r+p];
    for (int d = 0; d < W; d++) begin
      int c;
      c = r + d - HB;
      op_coef[d] = '0;
      op_x[d]    = '0;
      op_xv[d]   = 1'b0;
      if (c >= 0 && c < N) begin
        op_x[d]  = car_x[2*c+p];
        op_xv[d] = car_v[2*c+p];
        if (second)
          op_coef[d] = (c == tgt) ? DW'(1) : '0;
        else if (p == 1)
          op_coef[d] = mat_b[(r*N+c)*DW +: DW];
        else
          op_coef[d] = mat_a[(r*N+c)*DW +: DW];
      end
    end
  end

endmodule

// File: rtl/sched_cell.sv
// One systolic cell: adds its diagonal's product to the passing partial sum.
module sched_cell #(
  parameter int DW = 8,
  parameter int AW = 20,
  parameter int IW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [IW-1:0]        in_row,
  input  logic                 in_rv,
  input  logic signed [AW-1:0] in_acc,
  input  logic signed [DW-1:0] op_coef,
  input  logic signed [AW-1:0] op_x,
  input  logic                 op_xv,
  output logic                 out_vld,
  output logic [IW-1:0]        out_row,
  output logic                 out_rv,
  output logic signed [AW-1:0] out_acc
);

  logic signed [AW-1:0] coef_ext;
  logic signed [AW-1:0] term;

  assign coef_ext = AW'(op_coef);
  assign term     = op_xv ? coef_ext * op_x : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    out_row <= in_row;
    out_rv  <= in_rv;
    out_acc <= in_acc + term;
  end

  AST_DONTCARE_NO_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && !$past(op_xv) |-> out_acc == $past(in_acc)); // R4

endmodule

// File: rtl/sched_array.sv
// Linear chain of W cells; lane d's operands are delayed d cycles so they
// meet the partial sum when it reaches cell d.
module sched_array #(
  parameter int W  = 3,
  parameter int DW = 8,
  parameter int AW = 20,
  parameter int IW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [IW-1:0]        in_row,
  input  logic                 in_rv,
  input  logic signed [DW-1:0] op_coef [W],
  input  logic signed [AW-1:0] op_x [W],
  input  logic [W-1:0]         op_xv,
  output logic                 out_vld,
  output logic [IW-1:0]        out_row,
  output logic                 out_rv,
  output logic signed [AW-1:0] out_acc
);

  logic                 ch_vld [W+1];
  logic [IW-1:0]        ch_row [W+1];
  logic                 ch_rv  [W+1];
  logic signed [AW-1:0] ch_acc [W+1];

  assign ch_vld[0] = in_vld;
  assign ch_row[0] = in_row;
  assign ch_rv[0]  = in_rv;
  assign ch_acc[0] = '0;

  for (genvar d = 0; d < W; d++) begin : g_lane
    logic signed [DW-1:0] lane_c;
    logic signed [AW-1:0] lane_x;
    logic                 lane_v;

    if (d == 0) begin : g_direct
      assign lane_c = op_coef[0];
      assign lane_x = op_x[0];
      assign lane_v = op_xv[0];
    end else begin : g_dly
      logic signed [DW-1:0] c_q [d];
      logic signed [AW-1:0] x_q [d];
      logic [d-1:0]         v_q;
      always_ff @(posedge clk) begin
        c_q[0] <= op_coef[d];
        x_q[0] <= op_x[d];
        v_q[0] <= op_xv[d];
        for (int k = 1; k < d; k++) begin
          c_q[k] <= c_q[k-1];
          x_q[k] <= x_q[k-1];
          v_q[k] <= v_q[k-1];
        end
      end
      assign lane_c = c_q[d-1];
      assign lane_x = x_q[d-1];
      assign lane_v = v_q[d-1];
    end

    sched_cell #(.DW(DW), .AW(AW), .IW(IW)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (ch_vld[d]),
      .in_row  (ch_row[d]),
      .in_rv   (ch_rv[d]),
      .in_acc  (ch_acc[d]),
      .op_coef (lane_c),
      .op_x    (lane_x),
      .op_xv   (lane_v),
      .out_vld (ch_vld[d+1]),
      .out_row (ch_row[d+1]),
      .out_rv  (ch_rv[d+1]),
      .out_acc (ch_acc[d+1])
    );
  end

  assign out_vld = ch_vld[W];
  assign out_row = ch_row[W];
  assign out_rv  = ch_rv[W];
  assign out_acc = ch_acc[W];

endmodule

// File: rtl/dual_systolic_sched.sv
module dual_systolic_sched
  import sched_pkg::*;
#(
  parameter int N  = 4,
  parameter int W  = 3,
  parameter int DW = 8,
  parameter int AW = 2 * DW + 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [N*DW-1:0]     in_xa,
  input  logic [N-1:0]        in_xa_vld,
  input  logic [N*DW-1:0]     in_xb,
  input  logic [N-1:0]        in_xb_vld,
  input  logic [N*N*DW-1:0]   in_mat_a,
  input  logic [N*N*DW-1:0]   in_mat_b,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [N*AW-1:0]     out_a,
  output logic [N-1:0]        out_a_vld,
  output logic [N*AW-1:0]     out_b,
  output logic [N-1:0]        out_b_vld,
  output logic                out_pair_swap
);

  localparam int M  = 2 * N;
  localparam int IW = $clog2(M);
  localparam int CW = IW + 1;

  initial begin
    if (N % 2 != 0 || W % 2 == 0 || W < 3)
      $error("dual_systolic_sched: N must be even, W odd and at least 3");
  end

  sched_phase_e         phase;
  logic [CW-1:0]        inj;
  logic [CW-1:0]        col;
  logic                 swap_q;
  logic signed [AW-1:0] car_x [M];
  logic [M-1:0]         car_v;
  logic signed [AW-1:0] res_x [M];
  logic [M-1:0]         res_v;
  logic [N*N*DW-1:0]    mat_a_q;
  logic [N*N*DW-1:0]    mat_b_q;

  logic                 running;
  logic                 arr_in_vld;
  logic signed [DW-1:0] op_coef [W];
  logic signed [AW-1:0] op_x [W];
  logic [W-1:0]         op_xv;
  logic                 row_v;
  logic                 arr_out_vld;
  logic [IW-1:0]        arr_out_row;
  logic                 arr_out_rv;
  logic signed [AW-1:0] arr_out_acc;

  assign in_ready   = (phase == PH_IDLE);
  assign out_valid  = (phase == PH_DONE);
  assign running    = (phase == PH_RUN1) || (phase == PH_RUN2);
  assign arr_in_vld = running && (inj < CW'(M));

  sched_row_gen #(.N(N), .W(W), .DW(DW), .AW(AW)) u_row_gen (
    .second  (phase == PH_RUN2),
    .swap    (swap_q),
    .row     (inj[IW-1:0]),
    .car_x   (car_x),
    .car_v   (car_v),
    .mat_a   (mat_a_q),
    .mat_b   (mat_b_q),
    .op_coef (op_coef),
    .op_x    (op_x),
    .op_xv   (op_xv),
    .row_v   (row_v)
  );

  sched_array #(.W(W), .DW(DW), .AW(AW), .IW(IW)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (arr_in_vld),
    .in_row  (inj[IW-1:0]),
    .in_rv   (row_v),
    .op_coef (op_coef),
    .op_x    (op_x),
    .op_xv   (op_xv),
    .out_vld (arr_out_vld),
    .out_row (arr_out_row),
    .out_rv  (arr_out_rv),
    .out_acc (arr_out_acc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      inj     <= '0;
      col     <= '0;
      swap_q  <= 1'b0;
      car_v   <= '0;
      res_v   <= '0;
      mat_a_q <= '0;
      mat_b_q <= '0;
      for (int i = 0; i < M; i++) begin
        car_x[i] <= '0;
        res_x[i] <= '0;
      end
    end else begin
      case (phase)
        PH_IDLE: begin
          if (in_valid) begin
            for (int k = 0; k < N; k++) begin
              car_x[2*k]   <= AW'($signed(in_xa[k*DW +: DW]));
              car_x[2*k+1] <= AW'($signed(in_xb[k*DW +: DW]));
              car_v[2*k]   <= in_xa_vld[k];
              car_v[2*k+1] <= in_xb_vld[k];
            end
            mat_a_q <= in_mat_a;
            mat_b_q <= in_mat_b;
            swap_q  <= 1'b0;
            inj     <= '0;
            col     <= '0;
            phase   <= PH_RUN1;
          end
        end
        PH_RUN1, PH_RUN2: begin
          if (arr_in_vld) inj <= inj + 1'b1;
          if (arr_out_vld) begin
            res_x[arr_out_row] <= arr_out_rv ? arr_out_acc : '0;
            res_v[arr_out_row] <= arr_out_rv;
            col <= col + 1'b1;
            if (col == CW'(M - 1))
              phase <= (phase == PH_RUN1) ? PH_PICK : PH_DONE;
          end
        end
        PH_PICK: begin
          car_x  <= res_x;
          car_v  <= res_v;
          swap_q <= (res_x[0] == '0);
          inj    <= '0;
          col    <= '0;
          phase  <= PH_RUN2;
        end
        PH_DONE: begin
          if (out_ready) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_split
    assign out_a[k*AW +: AW] = res_x[2*k];
    assign out_b[k*AW +: AW] = res_x[2*k+1];
    assign out_a_vld[k]      = res_v[2*k];
    assign out_b_vld[k]      = res_v[2*k+1];
  end
  assign out_pair_swap = swap_q;

  AST_ROW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    arr_out_vld |-> arr_out_row == col[IW-1:0]); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_a) && $stable(out_b)
      && $stable(out_a_vld) && $stable(out_b_vld) && $stable(out_pair_swap)); // R7

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> in_ready && !out_valid); // R8

endmodule

// File: tb/dual_systolic_sched_bench.sv
module dual_systolic_sched_bench;

  localparam int N  = 4;
  localparam int W  = 3;
  localparam int DW = 8;
  localparam int AW = 2 * DW + 4;
  localparam int M  = 2 * N;
  localparam int HB = (W - 1) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [N*DW-1:0]   in_xa = '0;
  logic [N-1:0]      in_xa_vld = '0;
  logic [N*DW-1:0]   in_xb = '0;
  logic [N-1:0]      in_xb_vld = '0;
  logic [N*N*DW-1:0] in_mat_a = '0;
  logic [N*N*DW-1:0] in_mat_b = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [N*AW-1:0]   out_a;
  logic [N-1:0]      out_a_vld;
  logic [N*AW-1:0]   out_b;
  logic [N-1:0]      out_b_vld;
  logic              out_pair_swap;

  dual_systolic_sched #(.N(N), .W(W), .DW(DW), .AW(AW)) u_dual_systolic_sched (
    .clk, .rst_n, .in_valid, .in_ready, .in_xa, .in_xa_vld, .in_xb, .in_xb_vld,
    .in_mat_a, .in_mat_b, .out_valid, .out_ready, .out_a, .out_a_vld, .out_b,
    .out_b_vld, .out_pair_swap
  );

  int total = 0;
  int fails = 0;

  int xa [N];
  int xb [N];
  bit xav [N];
  bit xbv [N];
  int ma [N][N];
  int mb [N][N];

  longint ea [N];
  longint eb [N];
  bit     eav [N];
  bit     ebv [N];
  bit     exp_swap;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_job();
    for (int i = 0; i < N; i++) begin
      xa[i] = 0; xb[i] = 0; xav[i] = 1; xbv[i] = 1;
      for (int j = 0; j < N; j++) begin ma[i][j] = 0; mb[i][j] = 0; end
    end
  endtask

  // Reference: banded products, don't-care masking, pair selection, swap.
  task automatic model();
    longint s1 [M];
    bit     v1 [M];
    for (int i = 0; i < M; i++) begin
      int p = i % 2;
      int r = i / 2;
      longint s = 0;
      v1[i] = p ? xbv[r] : xav[r];
      for (int c = 0; c < N; c++) begin
        if (c - r <= HB && r - c <= HB) begin
          if (p ? xbv[c] : xav[c])
            s += longint'(p ? mb[r][c] : ma[r][c]) * longint'(p ? xb[c] : xa[c]);
        end
      end
      s1[i] = v1[i] ? s : 0;
    end
    exp_swap = (s1[0] == 0);
    for (int k = 0; k < N; k++) begin
      int src = exp_swap ? (k ^ 1) : k;
      ea[k] = s1[2*k];       eav[k] = v1[2*k];
      eb[k] = s1[2*src+1];   ebv[k] = v1[2*src+1];
    end
  endtask

  task automatic pack_inputs();
    for (int k = 0; k < N; k++) begin
      in_xa[k*DW +: DW] = DW'(xa[k]);
      in_xb[k*DW +: DW] = DW'(xb[k]);
      in_xa_vld[k] = xav[k];
      in_xb_vld[k] = xbv[k];
      for (int c = 0; c < N; c++) begin
        in_mat_a[(k*N+c)*DW +: DW] = DW'(ma[k][c]);
        in_mat_b[(k*N+c)*DW +: DW] = DW'(mb[k][c]);
      end
    end
  endtask

  task automatic run_job(input string req, input bit poke, input int hold);
    int  n;
    bit  busy_ok;
    logic [N*AW-1:0] snap_a;
    logic [N*AW-1:0] snap_b;
    pack_inputs();
    model();
    @(negedge clk);
    chk(in_ready == 1'b1, "R8", "in_ready idle before job", in_ready, 1);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    busy_ok = 1'b1;
    if (poke) begin
      in_valid  = 1'b1;
      in_xa     = '1;
      in_xb     = '1;
      in_mat_a  = '1;
      in_mat_b  = '1;
    end
    n = 0;
    while (!out_valid && n < 200) begin
      if (in_ready) busy_ok = 1'b0;
      @(negedge clk);
      n++;
    end
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R6", "out_valid after both passes", out_valid, 1);
    if (poke) chk(busy_ok, "R8", "in_ready low while busy", busy_ok, 1);
    snap_a = out_a;
    snap_b = out_b;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(out_valid == 1'b1 && out_a == snap_a && out_b == snap_b, "R7",
          "result held under back-pressure", out_valid, 1);
    end
    for (int k = 0; k < N; k++) begin
      longint aa = longint'($signed(out_a[k*AW +: AW]));
      longint bb = longint'($signed(out_b[k*AW +: AW]));
      chk(aa == ea[k], req, $sformatf("out_a[%0d]", k), aa, ea[k]);
      chk(bb == eb[k], req, $sformatf("out_b[%0d]", k), bb, eb[k]);
      chk(out_a_vld[k] == eav[k], req, $sformatf("out_a_vld[%0d]", k), out_a_vld[k], eav[k]);
      chk(out_b_vld[k] == ebv[k], req, $sformatf("out_b_vld[%0d]", k), out_b_vld[k], ebv[k]);
    end
    chk(out_pair_swap == exp_swap, "R5", "out_pair_swap", out_pair_swap, exp_swap);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R8", "release after handshake",
        {out_valid, in_ready}, 2'b01);
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
  endtask

  // Hadamard pattern on (1,0) beside identity on (1,0): A=(1,1), B=(1,0), no swap.
  task automatic t_hadamard();
    clear_job();
    ma[0][0] = 1; ma[0][1] = 1; ma[1][0] = 1; ma[1][1] = -1;
    for (int i = 0; i < N; i++) mb[i][i] = 1;
    xa[0] = 1; xb[0] = 1;
    run_job("R2", 1'b0, 0);
    chk(ea[0] == 1 && ea[1] == 1 && eb[0] == 1 && eb[1] == 0 && !exp_swap, "R6",
        "reference for Hadamard case", ea[1], 1);
  endtask

  // First carrier component zero: B is pair-swapped.
  task automatic t_swap();
    clear_job();
    for (int i = 0; i < N; i++) ma[i][i] = 1;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (i - j <= 1 && j - i <= 1) mb[i][j] = i + 2 * j - 1;
    xa[0] = 0; xa[1] = 5; xa[2] = 3; xa[3] = -2;
    xb[0] = 1; xb[1] = 2; xb[2] = -3; xb[3] = 4;
    run_job("R5", 1'b0, 0);
  endtask

  // Don't-care operands, once with A[0] valid and once with A[0] don't-care.
  task automatic t_dontcare();
    clear_job();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (i - j <= 1 && j - i <= 1) begin ma[i][j] = 2; mb[i][j] = j + 1; end
    xa[0] = 3; xa[1] = 99; xa[2] = 1; xa[3] = 2;
    xb[0] = 4; xb[1] = -1; xb[2] = 2; xb[3] = 77;
    xav[1] = 0; xbv[3] = 0;
    run_job("R4", 1'b0, 0);
    xav[1] = 1; xav[0] = 0; xa[0] = 50;
    run_job("R4", 1'b0, 0);
  endtask

  // Out-of-band entries set large; outputs must match the band-only reference.
  task automatic t_band();
    clear_job();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        if (i - j <= 1 && j - i <= 1) begin ma[i][j] = i - j + 1; mb[i][j] = 1; end
        else begin ma[i][j] = 100; mb[i][j] = -100; end
      end
    xa[0] = 2; xa[1] = 1; xa[2] = 3; xa[3] = 1;
    xb[0] = 1; xb[1] = 1; xb[2] = 2; xb[3] = 3;
    run_job("R3", 1'b0, 0);
  endtask

  // Back-pressure on the result and a job offered while busy.
  task automatic t_backpressure();
    clear_job();
    for (int i = 0; i < N; i++) begin ma[i][i] = 3; mb[i][i] = -1; end
    xa[0] = 1; xa[1] = 2; xa[2] = 3; xa[3] = 4;
    xb[0] = 5; xb[1] = 6; xb[2] = 7; xb[3] = 8;
    run_job("R7", 1'b1, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hadamard();
    t_swap();
    t_dontcare();
    t_band();
    t_backpressure();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R6 watchdog expired: actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule